// File: doc/BRIEF.md
# Self-Routing Omega Multistage Network

This block joins P = 2^N requesters to P targets through N identical stages. Each stage first applies a perfect-shuffle permutation to the lines. The shuffle is a one-bit left rotation of the N-bit line index. A column of P/2 two-by-two switches follows the shuffle. Each request carries a valid bit, an N-bit target index and a payload. The switches steer it using nothing but the target index, so no central controller is needed. After the last stage, a delivered request appears on the output whose number equals its target index. That output also carries the payload and the number of the input it came from.

The network is blocking. Two requests with different targets can still need the same inter-stage link. Such a clash is settled on the spot inside the switch: the request from the lower-numbered input keeps the link, and the other request is discarded. The discarded request's input sees its blocked flag raised in the same result cycle. Nothing is queued or retried; the requester decides what to do next. A parameter selects one register stage on all outputs, which adds one cycle of latency. With that parameter off, the block is purely combinational.

Top module: `omega_net`

## Requirements
- R1: A request that is not blocked appears on exactly one output, and that output's index equals the request's target index.
- R2: A delivered output reports on `out_src` the number of the input the request came from, and on `out_data` that input's payload unchanged.
- R3: Stage k (first stage k = 0) sends a request to the switch port given by target bit N-1-k. Two valid surviving requests clash after stage k when they agree on source bits [N-2-k:0] and on target bits [N-1:N-1-k]. For example, with P = 8, input 2 to target 7 and input 6 to target 4 clash in the first stage.
- R4: In a clash, the request from the lower-numbered input wins. The losing request appears on no output, and its input's bit in `in_blocked` is 1.
- R5: An input with valid low takes no link, never causes another request to be blocked, and its own blocked flag stays 0.
- R6: Every valid request is either delivered or blocked, never both: popcount(`in_valid`) = popcount(`out_valid`) + popcount(`in_blocked`).
- R7: The identity pattern and every uniform cyclic shift (target = (source + c) mod P) are delivered with no blocking.
- R8: With `REG_OUT` = 1, results appear one clock after the inputs are presented. A synchronous active-low reset clears `out_valid` and `in_blocked` to 0.
- R9: An output that receives no request shows `out_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | P | Request present, one bit per input |
| in_dst | input | P*N | Target index per input; input i uses bits [N*i +: N] |
| in_data | input | P*DATA_W | Payload per input; input i uses bits [DATA_W*i +: DATA_W] |
| in_blocked | output | P | Request of that input lost a link clash |
| out_valid | output | P | A request arrived on this output |
| out_src | output | P*N | Source input number per output, same packing as in_dst |
| out_data | output | P*DATA_W | Payload per output, same packing as in_data |

## Verification
The identity pattern and all eight cyclic shifts must pass without loss, so they isolate the wiring of the shuffle and the switch steering from the clash logic. Bit reversal, all-to-one and the paired 2→7 / 6→4 case force clashes at the first, middle and last stages, and they show whether the winner follows input order. Sparse patterns with idle inputs show that an invalid request never steals a link. Random loads and random full permutations are compared against a link-occupancy model that walks the stages in input order.

// File: rtl/omega_pkg.sv
// Package: omega_pkg
// Shared helpers for the omega network. The shuffle target of a line is
// its index rotated left by one bit inside an n-bit field.
package omega_pkg;

    // Perfect-shuffle destination of line idx in an nbits-wide index space.
    function automatic int shuffle_dest(input int idx, input int nbits);
        int span;
        span = 1 << nbits;
        return ((idx * 2) % span) + (idx / (span / 2));
    endfunction

endpackage

// File: rtl/omega_switch.sv
// Module: omega_switch
// One 2x2 self-routing element in stage STAGE. Each input picks output
// port = target bit (N-1-STAGE). When both valid inputs pick the same port,
// the lower source number wins; the loser is reported on loss_*.
// Assumes the two inputs never carry the same source number.
module omega_switch #(
    parameter int N     = 3,
    parameter int W     = 8,
    parameter int STAGE = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         a_vld,
    input  logic [N-1:0] a_dst,
    input  logic [N-1:0] a_src,
    input  logic [W-1:0] a_dat,
    input  logic         b_vld,
    input  logic [N-1:0] b_dst,
    input  logic [N-1:0] b_src,
    input  logic [W-1:0] b_dat,
    output logic         o0_vld,
    output logic [N-1:0] o0_dst,
    output logic [N-1:0] o0_src,
    output logic [W-1:0] o0_dat,
    output logic         o1_vld,
    output logic [N-1:0] o1_dst,
    output logic [N-1:0] o1_src,
    output logic [W-1:0] o1_dat,
    output logic         loss_vld,
    output logic [N-1:0] loss_src
);
    localparam int BIT = N - 1 - STAGE;

    logic a_port, b_port, clash, a_wins, a_go, b_go;

    // Port requests and clash detection.
    always_comb begin
        a_port   = a_dst[BIT];
        b_port   = b_dst[BIT];
        clash    = a_vld && b_vld && (a_port == b_port);
        a_wins   = (a_src < b_src);
        a_go     = a_vld && (!clash || a_wins);
        b_go     = b_vld && (!clash || !a_wins);
        loss_vld = clash;
        loss_src = a_wins ? b_src : a_src;
    end

    // Steer each surviving request onto its chosen output port.
    always_comb begin
        o0_vld = 1'b0; o0_dst = '0; o0_src = '0; o0_dat = '0;
        o1_vld = 1'b0; o1_dst = '0; o1_src = '0; o1_dat = '0;
        if (b_go) begin
            if (b_port) begin
                o1_vld = 1'b1; o1_dst = b_dst; o1_src = b_src; o1_dat = b_dat;
            end else begin
                o0_vld = 1'b1; o0_dst = b_dst; o0_src = b_src; o0_dat = b_dat;
            end
        end
        if (a_go) begin
            if (a_port) begin
                o1_vld = 1'b1; o1_dst = a_dst; o1_src = a_src; o1_dat = a_dat;
            end else begin
                o0_vld = 1'b1; o0_dst = a_dst; o0_src = a_src; o0_dat = a_dat;
            end
        end
    end

    // A clash leaves exactly one of the two ports carrying a request.
    assert_one_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clash |-> (o0_vld ^ o1_vld));

    // Whatever leaves a port has the matching target bit for this stage.
    assert_port_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!o0_vld || !o0_dst[BIT]) && (!o1_vld || o1_dst[BIT]));

endmodule

// File: rtl/omega_stage.sv
// Module: omega_stage
// One network stage: perfect-shuffle wiring of P = 2^N lines, then P/2
// switches on line pairs (2j, 2j+1). o_blk marks the sources dropped here.
module omega_stage
    import omega_pkg::*;
#(
    parameter int N     = 3,
    parameter int W     = 8,
    parameter int STAGE = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [(1<<N)-1:0]             i_vld,
    input  logic [(1<<N)-1:0][N-1:0]      i_dst,
    input  logic [(1<<N)-1:0][N-1:0]      i_src,
    input  logic [(1<<N)-1:0][W-1:0]      i_dat,
    output logic [(1<<N)-1:0]             o_vld,
    output logic [(1<<N)-1:0][N-1:0]      o_dst,
    output logic [(1<<N)-1:0][N-1:0]      o_src,
    output logic [(1<<N)-1:0][W-1:0]      o_dat,
    output logic [(1<<N)-1:0]             o_blk
);
    localparam int P    = 1 << N;
    localparam int HALF = P / 2;

    logic [P-1:0]         s_vld;
    logic [P-1:0][N-1:0]  s_dst;
    logic [P-1:0][N-1:0]  s_src;
    logic [P-1:0][W-1:0]  s_dat;
    logic [HALF-1:0]      loss_vld;
    logic [HALF-1:0][N-1:0] loss_src;

    // Shuffle wiring: line i moves to its left-rotated index.
    for (genvar i = 0; i < P; i++) begin : g_shuf
        localparam int J = shuffle_dest(i, N);
        assign s_vld[J] = i_vld[i];
        assign s_dst[J] = i_dst[i];
        assign s_src[J] = i_src[i];
        assign s_dat[J] = i_dat[i];
    end

    // Column of switches on adjacent line pairs.
    for (genvar j = 0; j < HALF; j++) begin : g_sw
        omega_switch #(.N(N), .W(W), .STAGE(STAGE)) u_sw (
            .clk      (clk),
            .rst_n    (rst_n),
            .a_vld    (s_vld[2*j]),
            .a_dst    (s_dst[2*j]),
            .a_src    (s_src[2*j]),
            .a_dat    (s_dat[2*j]),
            .b_vld    (s_vld[2*j+1]),
            .b_dst    (s_dst[2*j+1]),
            .b_src    (s_src[2*j+1]),
            .b_dat    (s_dat[2*j+1]),
            .o0_vld   (o_vld[2*j]),
            .o0_dst   (o_dst[2*j]),
            .o0_src   (o_src[2*j]),
            .o0_dat   (o_dat[2*j]),
            .o1_vld   (o_vld[2*j+1]),
            .o1_dst   (o_dst[2*j+1]),
            .o1_src   (o_src[2*j+1]),
            .o1_dat   (o_dat[2*j+1]),
            .loss_vld (loss_vld[j]),
            .loss_src (loss_src[j])
        );
    end

    // Decode the losers of this stage into a per-source mask.
    always_comb begin
        o_blk = '0;
        for (int j = 0; j < HALF; j++) begin
            if (loss_vld[j]) o_blk[loss_src[j]] = 1'b1;
        end
    end

endmodule

// File: rtl/omega_outreg.sv
// Module: omega_outreg
// Optional result register. REG_OUT = 1 inserts one clocked stage with a
// synchronous active-low reset on the valid and blocked bits; REG_OUT = 0
// passes everything straight through.
module omega_outreg #(
    parameter int P       = 8,
    parameter int N       = 3,
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [P-1:0]         d_vld,
    input  logic [P-1:0][N-1:0]  d_src,
    input  logic [P-1:0][W-1:0]  d_dat,
    input  logic [P-1:0]         d_blk,
    output logic [P-1:0]         q_vld,
    output logic [P-1:0][N-1:0]  q_src,
    output logic [P-1:0][W-1:0]  q_dat,
    output logic [P-1:0]         q_blk
);
    if (REG_OUT) begin : g_reg
        // Capture the network result once per clock.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_vld <= '0;
                q_blk <= '0;
                q_src <= '0;
                q_dat <= '0;
            end else begin
                q_vld <= d_vld;
                q_blk <= d_blk;
                q_src <= d_src;
                q_dat <= d_dat;
            end
        end
    end else begin : g_wire
        assign q_vld = d_vld;
        assign q_blk = d_blk;
        assign q_src = d_src;
        assign q_dat = d_dat;
    end

endmodule

// File: rtl/omega_net.sv
// Module: omega_net
// Top of the omega network: LOG_P stages of shuffle plus switches, the
// per-stage loss masks merged into one blocked vector, and an optional
// output register. Assumes in_* are stable around the sampling clock edge.
module omega_net #(
    parameter int LOG_P   = 3,
    parameter int DATA_W  = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [(1<<LOG_P)-1:0]         in_valid,
    input  logic [(1<<LOG_P)*LOG_P-1:0]   in_dst,
    input  logic [(1<<LOG_P)*DATA_W-1:0]  in_data,
    output logic [(1<<LOG_P)-1:0]         in_blocked,
    output logic [(1<<LOG_P)-1:0]         out_valid,
    output logic [(1<<LOG_P)*LOG_P-1:0]   out_src,
    output logic [(1<<LOG_P)*DATA_W-1:0]  out_data
);
    localparam int P = 1 << LOG_P;
    localparam int N = LOG_P;
    localparam int W = DATA_W;

    logic [N:0][P-1:0]         lv_vld;
    logic [N:0][P-1:0][N-1:0]  lv_dst;
    logic [N:0][P-1:0][N-1:0]  lv_src;
    logic [N:0][P-1:0][W-1:0]  lv_dat;
    logic [N-1:0][P-1:0]       stg_blk;
    logic [P-1:0]              net_blk;
    logic [P-1:0][N-1:0]       q_src;
    logic [P-1:0][W-1:0]       q_dat;

    // Level 0: requests tagged with their own input number.
    assign lv_vld[0] = in_valid;
    assign lv_dst[0] = in_dst;
    assign lv_dat[0] = in_data;
    for (genvar i = 0; i < P; i++) begin : g_tag
        assign lv_src[0][i] = N'(i);
    end

    // Stage chain.
    for (genvar k = 0; k < N; k++) begin : g_stage
        omega_stage #(.N(N), .W(W), .STAGE(k)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .i_vld (lv_vld[k]),
            .i_dst (lv_dst[k]),
            .i_src (lv_src[k]),
            .i_dat (lv_dat[k]),
            .o_vld (lv_vld[k+1]),
            .o_dst (lv_dst[k+1]),
            .o_src (lv_src[k+1]),
            .o_dat (lv_dat[k+1]),
            .o_blk (stg_blk[k])
        );
    end

    // Merge the loss masks of all stages.
    always_comb begin
        net_blk = '0;
        for (int k = 0; k < N; k++) net_blk = net_blk | stg_blk[k];
    end

    omega_outreg #(.P(P), .N(N), .W(W), .REG_OUT(REG_OUT)) u_outreg (
        .clk   (clk),
        .rst_n (rst_n),
        .d_vld (lv_vld[N]),
        .d_src (lv_src[N]),
        .d_dat (lv_dat[N]),
        .d_blk (net_blk),
        .q_vld (out_valid),
        .q_src (q_src),
        .q_dat (q_dat),
        .q_blk (in_blocked)
    );
    assign out_src  = q_src;
    assign out_data = q_dat;

    // Every request is delivered or dropped, never both nor neither.
    assert_conserve_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(in_valid) == $countones(lv_vld[N]) + $countones(net_blk));

    // An idle input is never reported as blocked.
    assert_idle_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (net_blk & ~in_valid) == '0);

    for (genvar o = 0; o < P; o++) begin : g_chk
        // A request leaving output o was addressed to o.
        assert_dest_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
            lv_vld[N][o] |-> (lv_dst[N][o] == N'(o)));
        // A delivered source is not also flagged as a loser.
        assert_loser_absent_R4: assert property (@(posedge clk) disable iff (!rst_n)
            lv_vld[N][o] |-> !net_blk[lv_src[N][o]]);
    end

endmodule

// File: tb/omega_net_tb.sv
module omega_net_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 3;
    localparam int P = 8;
    localparam int W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [P-1:0]     in_valid = '0;
    logic [P*N-1:0]   in_dst = '0;
    logic [P*W-1:0]   in_data = '0;
    logic [P-1:0]     in_blocked;
    logic [P-1:0]     out_valid;
    logic [P*N-1:0]   out_src;
    logic [P*W-1:0]   out_data;

    int total = 0;
    int bad = 0;
    int seq = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    omega_net #(.LOG_P(N), .DATA_W(W), .REG_OUT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst),
        .in_data(in_data), .in_blocked(in_blocked), .out_valid(out_valid),
        .out_src(out_src), .out_data(out_data)
    );

    // {valid[7:0], dst[23:0] (input i at [3i+:3]), expected blocked[7:0]}
    localparam logic [39:0] VEC [8] = '{
        40'hFF_FAC688_00,  // identity, no loss (R7, R1)
        40'hFF_1F58D1_00,  // shift by one, no loss (R7)
        40'h44_1001C0_40,  // 2->7 and 6->4 clash at stage 0, input 6 loses (R3, R4)
        40'hFF_EE9CA0_F0,  // bit reversal: inputs 4..7 lose at stage 0 (R3, R4)
        40'hFF_000000_FE,  // all to 0: losses at every stage (R3, R4)
        40'h40_1001C0_00,  // input 2 idle, so 6->4 gets through (R5)
        40'hA0_000000_80,  // 5 and 7 to 0 clash at stage 1, 5 wins (R4)
        40'h00_FAC688_00   // nothing valid, outputs idle (R9, R5)
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [P-1:0] v, input logic [P*N-1:0] d);
        @(negedge clk);
        seq++;
        in_valid = v;
        in_dst   = d;
        for (int i = 0; i < P; i++) in_data[i*W +: W] = W'(seq * 8 + i);
    endtask

    // Link-occupancy model: stage k link key = {src low bits, dst top k+1 bits}.
    function automatic logic [P-1:0] model_blk(input logic [P-1:0] v,
                                               input logic [P*N-1:0] d);
        logic [P-1:0] alive;
        logic [P-1:0] blk;
        alive = v;
        blk = '0;
        for (int k = 0; k < N; k++) begin
            logic [P-1:0] taken;
            taken = '0;
            for (int s = 0; s < P; s++) begin
                if (alive[s]) begin
                    int key;
                    key = ((s << (k + 1)) | (int'(d[s*N +: N]) >> (N - 1 - k))) & (P - 1);
                    if (taken[key]) begin
                        alive[s] = 1'b0;
                        blk[s] = 1'b1;
                    end else taken[key] = 1'b1;
                end
            end
        end
        return blk;
    endfunction

    // Compare all outputs after one clock of latency against the rules.
    task automatic check_vec(input logic [P-1:0] v, input logic [P*N-1:0] d,
                             input logic [P-1:0] eb, input string tag);
        @(posedge clk); #1;
        for (int o = 0; o < P; o++) begin
            bit ev;
            int es;
            ev = 0; es = 0;
            for (int s = 0; s < P; s++)
                if (v[s] && !eb[s] && int'(d[s*N +: N]) == o) begin ev = 1; es = s; end
            check(out_valid[o] == ev, ev ? "R1" : "R9", {tag, " out_valid"},
                  int'(out_valid[o]), int'(ev));
            if (ev && out_valid[o]) begin
                check(int'(out_src[o*N +: N]) == es, "R2", {tag, " out_src"},
                      int'(out_src[o*N +: N]), es);
                check(int'(out_data[o*W +: W]) == ((seq * 8 + es) & 255), "R2",
                      {tag, " out_data"}, int'(out_data[o*W +: W]), (seq * 8 + es) & 255);
            end
        end
        check(in_blocked == eb, "R4", {tag, " in_blocked"}, int'(in_blocked), int'(eb));
        check($countones(v) == $countones(out_valid) + $countones(in_blocked), "R6",
              {tag, " conservation"}, $countones(out_valid) + $countones(in_blocked),
              $countones(v));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R8: reset clears outputs even with traffic on the inputs.
        in_valid = '1;
        in_dst = 24'hFAC688;
        repeat (2) @(posedge clk);
        #1;
        check(out_valid == '0, "R8", "reset out_valid", int'(out_valid), 0);
        check(in_blocked == '0, "R8", "reset in_blocked", int'(in_blocked), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table of patterns.
        for (int t = 0; t < 8; t++) begin
            apply(VEC[t][39:32], VEC[t][31:8]);
            check_vec(VEC[t][39:32], VEC[t][31:8], VEC[t][7:0], $sformatf("vec%0d", t));
        end

        // R7: every cyclic shift passes without loss.
        for (int c = 0; c < P; c++) begin
            logic [P*N-1:0] d;
            for (int i = 0; i < P; i++) d[i*N +: N] = N'((i + c) % P);
            apply('1, d);
            check_vec('1, d, '0, $sformatf("R7 shift%0d", c));
        end

        // R1/R3/R4: random full permutations against the link model.
        for (int r = 0; r < 30; r++) begin
            int perm [P];
            logic [P*N-1:0] d;
            for (int i = 0; i < P; i++) perm[i] = i;
            for (int i = P - 1; i > 0; i--) begin
                int j, tmp;
                j = $urandom_range(i, 0);
                tmp = perm[i]; perm[i] = perm[j]; perm[j] = tmp;
            end
            for (int i = 0; i < P; i++) d[i*N +: N] = N'(perm[i]);
            apply('1, d);
            check_vec('1, d, model_blk('1, d), $sformatf("R3 perm%0d", r));
        end

        // R5/R6: random sparse loads with repeated targets.
        for (int r = 0; r < 40; r++) begin
            logic [P-1:0] v;
            logic [P*N-1:0] d;
            v = P'($urandom);
            d = (P*N)'($urandom);
            apply(v, d);
            check_vec(v, d, model_blk(v, d), $sformatf("R5 rand%0d", r));
        end

        // R8: one cycle of latency: old result holds until the next edge.
        apply('1, 24'hFAC688);
        @(posedge clk);
        apply('0, 24'hFAC688);
        #1;
        check(out_valid == '1, "R8", "latency hold", int'(out_valid), 255);
        @(posedge clk); #1;
        check(out_valid == '0, "R8", "latency update", int'(out_valid), 0);

        // R8: reset in the middle of traffic clears valid and blocked.
        apply('1, 24'h000000);
        @(posedge clk); #1;
        check(in_blocked == 8'hFE, "R4", "pre-reset blocked", int'(in_blocked), 254);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check(out_valid == '0, "R8", "mid reset out_valid", int'(out_valid), 0);
        check(in_blocked == '0, "R8", "mid reset in_blocked", int'(in_blocked), 0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule